// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a small synchronous SRAM with a pipelined read path and four-beat bursts. It stores words of `LANES` byte lanes, each `LANE_W` bits wide (36 bits by default), in `2**ADDR_W` locations. A system starts an access with one of two active-low address strobes. The processor strobe always reads. The controller strobe samples the write controls in the same cycle. After the start, an active-low advance input steps through the rest of a four-word group. The step order can be linear or interleaved.

Every input is captured on the rising clock edge into a request register. The storage array is accessed from that register on the next edge, and read data lands in an output register. The data bus is split into a data-in port, a data-out port and a driver-enable output, so no tri-state logic is needed. A sleep input stops all accesses and keeps the stored contents. An active-low output enable gates the driver enable directly, without a register.

Top module: `sync_burst_sram`

## Requirements
- R1: The part is selected only when `en_a_n`=0, `en_b`=1 and `en_c_n`=0. A strobe sampled while the part is not selected starts no access and ends any burst. The driver enable is low after the second following edge.
- R2: When a processor-strobe read is sampled at edge k, data from that address is on `rdata` and `rdata_drv` is high after edge k+1, provided `out_en_n` is low. After edge k alone, the output still reflects the earlier access.
- R3: A processor-strobe start is always a read, and the write controls are ignored in that cycle. When both strobes are low, the processor strobe wins.
- R4: A controller-strobe start writes the full word when `write_all_n`=0. It also writes the full word when `write_all_n`=1, `byte_wr_en_n`=0 and `lane_wr_n`=4'b0000.
- R5: With `write_all_n`=1 and `byte_wr_en_n`=0, a low `lane_wr_n[i]` writes bits [9i+8:9i], and the other lanes keep their contents. If no lane is selected, a controller-strobe start is a read.
- R6: After a write, `rdata_drv` stays low until a new read is started by a strobe.
- R7: In linear order (`burst_il`=0), each cycle with `advance_n` low sets the low two address bits to (start + count) mod 4. The upper address bits stay fixed. This holds for both read and write bursts.
- R8: In interleaved order (`burst_il`=1, sampled at the burst start), the low two bits are start XOR count.
- R9: When `advance_n` is high and neither strobe is low, the burst address is held and the previous operation repeats. A read burst re-reads the same word, and a write burst rewrites it with the current data.
- R10: `out_en_n` high forces `rdata_drv` low in the same cycle, with no clock edge needed. Setting it low again restores the read data.
- R11: While `sleep` is high, no read or write takes place and the contents are kept. On leaving sleep, the output is not driven until a new read starts.
- R12: After reset, `rdata_drv` is low and no burst is in progress, so `advance_n` alone starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | ADDR_W | Word address loaded at a burst start |
| proc_strobe_n | input | 1 | Active-low read start strobe |
| ctrl_strobe_n | input | 1 | Active-low start strobe that samples the write controls |
| advance_n | input | 1 | Active-low burst step |
| en_a_n | input | 1 | Active-low select |
| en_b | input | 1 | Active-high select |
| en_c_n | input | 1 | Active-low select |
| write_all_n | input | 1 | Active-low full-word write |
| byte_wr_en_n | input | 1 | Active-low enable for the per-lane strobes |
| lane_wr_n | input | LANES | Active-low per-lane write strobes |
| burst_il | input | 1 | Interleaved burst order when high, sampled at the start |
| sleep | input | 1 | Stops all accesses while high |
| out_en_n | input | 1 | Active-low gate on the driver enable |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_drv | output | 1 | High when the data bus should be driven |

## Verification
The hardest state to reach from the ports is a burst that wraps inside its four-word group while its step sequence is broken by a hold. It must also be tested in the interleaved order, where the wrap point depends on the start offset. The stimulus first fills one group with distinct words. It then starts a read in the middle of the group and toggles the advance input on chosen cycles. Each word is predicted from the requirement's modulo or XOR rule and checked two edges after its step. A write burst that holds on one address checks the repeat path for writes as well.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } sbs_op_e;
endpackage

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
    parameter int BURST_BITS = 2
) (
    input  logic [BURST_BITS-1:0] start_i,
    input  logic [BURST_BITS-1:0] count_i,
    input  logic                  il_i,
    output logic [BURST_BITS-1:0] off_o
);
    // Offset of the current beat inside the group.
    always_comb begin
        if (il_i) off_o = start_i ^ count_i;
        else      off_o = start_i + count_i;
    end
endmodule

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int LANES      = 4,
    parameter int LANE_W     = 9,
    parameter int BURST_BITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    proc_strobe_n_i,
    input  logic                    ctrl_strobe_n_i,
    input  logic                    advance_n_i,
    input  logic                    sel_i,
    input  logic                    write_all_n_i,
    input  logic                    byte_wr_en_n_i,
    input  logic [LANES-1:0]        lane_wr_n_i,
    input  logic                    burst_il_i,
    input  logic                    sleep_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output sbs_op_e                 req_op_o,
    output logic [ADDR_W-1:0]       req_addr_o,
    output logic [LANES-1:0]        req_mask_o,
    output logic [LANES*LANE_W-1:0] req_wdata_o
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int HI_W   = ADDR_W - BURST_BITS;

    typedef struct packed {
        logic                  active;
        sbs_op_e               bop;
        logic                  il;
        logic [HI_W-1:0]       hi;
        logic [BURST_BITS-1:0] start;
        logic [BURST_BITS-1:0] cnt;
        sbs_op_e               op;
        logic [ADDR_W-1:0]     addr;
        logic [LANES-1:0]      mask;
        logic [DATA_W-1:0]     wdata;
    } ctrl_st_t;

    localparam ctrl_st_t ST_RESET = '{
        active: 1'b0, bop: OP_NONE, il: 1'b0, hi: '0, start: '0,
        cnt: '0, op: OP_NONE, addr: '0, mask: '0, wdata: '0
    };

    ctrl_st_t st_d, st_q;

    logic [BURST_BITS-1:0] cnt_inc;
    logic [BURST_BITS-1:0] adv_off;
    logic [LANES-1:0]      mask_now;

    assign cnt_inc  = st_q.cnt + 1'b1;
    assign mask_now = !write_all_n_i  ? {LANES{1'b1}} :
                      !byte_wr_en_n_i ? ~lane_wr_n_i  : {LANES{1'b0}};

    sbs_burst_seq #(.BURST_BITS(BURST_BITS)) u_seq (
        .start_i (st_q.start),
        .count_i (cnt_inc),
        .il_i    (st_q.il),
        .off_o   (adv_off)
    );

    always_comb begin
        st_d       = st_q;
        st_d.wdata = wdata_i;
        if (sleep_i) begin
            st_d.active = 1'b0;
            st_d.op     = OP_NONE;
            st_d.mask   = '0;
        end else if ((!proc_strobe_n_i || !ctrl_strobe_n_i) && sel_i) begin
            st_d.active = 1'b1;
            st_d.il     = burst_il_i;
            st_d.hi     = addr_i[ADDR_W-1:BURST_BITS];
            st_d.start  = addr_i[BURST_BITS-1:0];
            st_d.cnt    = '0;
            st_d.addr   = addr_i;
            if (!proc_strobe_n_i || mask_now == '0) begin
                st_d.bop  = OP_RD;
                st_d.op   = OP_RD;
                st_d.mask = '0;
            end else begin
                st_d.bop  = OP_WR;
                st_d.op   = OP_WR;
                st_d.mask = mask_now;
            end
        end else if (!proc_strobe_n_i || !ctrl_strobe_n_i) begin
            st_d.active = 1'b0;
            st_d.op     = OP_NONE;
            st_d.mask   = '0;
        end else if (st_q.active) begin
            if (!advance_n_i) begin
                st_d.cnt  = cnt_inc;
                st_d.addr = {st_q.hi, adv_off};
            end
            if (st_q.bop == OP_WR) begin
                st_d.mask = mask_now;
                st_d.op   = (mask_now != '0) ? OP_WR : OP_NONE;
            end else begin
                st_d.mask = '0;
                st_d.op   = OP_RD;
            end
        end else begin
            st_d.op   = OP_NONE;
            st_d.mask = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign req_op_o    = st_q.op;
    assign req_addr_o  = st_q.addr;
    assign req_mask_o  = st_q.mask;
    assign req_wdata_o = st_q.wdata;
endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we_i,
    input  logic [LANES-1:0]        mask_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    output logic [LANES*LANE_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i && mask_i[g]) mem[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
        end

        assign rdata_o[g*LANE_W +: LANE_W] = mem[addr_i];
    end
endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              out_en_n_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drv_o
);
    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.drive = rd_i;
        if (rd_i) st_d.data = rdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.data;
    assign drv_o   = st_q.drive && !out_en_n_i;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int LANES      = 4,
    parameter int LANE_W     = 9,
    parameter int BURST_BITS = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    proc_strobe_n,
    input  logic                    ctrl_strobe_n,
    input  logic                    advance_n,
    input  logic                    en_a_n,
    input  logic                    en_b,
    input  logic                    en_c_n,
    input  logic                    write_all_n,
    input  logic                    byte_wr_en_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    burst_il,
    input  logic                    sleep,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_drv
);
    localparam int DATA_W = LANES * LANE_W;

    sbs_op_e             req_op;
    logic [ADDR_W-1:0]   req_addr;
    logic [LANES-1:0]    req_mask;
    logic [DATA_W-1:0]   req_wdata;
    logic [DATA_W-1:0]   arr_rdata;
    logic                sel;

    assign sel = !en_a_n && en_b && !en_c_n;

    sbs_ctrl #(
        .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .BURST_BITS(BURST_BITS)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .addr_i          (addr),
        .proc_strobe_n_i (proc_strobe_n),
        .ctrl_strobe_n_i (ctrl_strobe_n),
        .advance_n_i     (advance_n),
        .sel_i           (sel),
        .write_all_n_i   (write_all_n),
        .byte_wr_en_n_i  (byte_wr_en_n),
        .lane_wr_n_i     (lane_wr_n),
        .burst_il_i      (burst_il),
        .sleep_i         (sleep),
        .wdata_i         (wdata),
        .req_op_o        (req_op),
        .req_addr_o      (req_addr),
        .req_mask_o      (req_mask),
        .req_wdata_o     (req_wdata)
    );

    sbs_lane_array #(
        .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
    ) u_array (
        .clk     (clk),
        .we_i    (req_op == OP_WR),
        .mask_i  (req_mask),
        .addr_i  (req_addr),
        .wdata_i (req_wdata),
        .rdata_o (arr_rdata)
    );

    sbs_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (req_op == OP_RD),
        .rdata_i    (arr_rdata),
        .out_en_n_i (out_en_n),
        .rdata_o    (rdata),
        .drv_o      (rdata_drv)
    );
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_strobe_n,
    input logic              ctrl_strobe_n,
    input logic              advance_n,
    input logic              en_a_n,
    input logic              en_b,
    input logic              en_c_n,
    input logic              write_all_n,
    input logic              sleep,
    input logic              out_en_n,
    input logic              rdata_drv,
    input sbs_op_e           req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LANES-1:0]  req_mask
);
    logic chk_sel;
    assign chk_sel = !en_a_n && en_b && !en_c_n;

    a_r1_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && (!proc_strobe_n || !ctrl_strobe_n) && !chk_sel) |-> ##2 !rdata_drv);

    a_r2_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !proc_strobe_n && chk_sel) |-> ##2 (rdata_drv || out_en_n));

    a_r3_proc_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !proc_strobe_n && chk_sel) |=> (req_op == OP_RD));

    a_r4_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_WR) |-> (req_mask != '0));

    a_r6_write_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && proc_strobe_n && !ctrl_strobe_n && chk_sel && !write_all_n)
        |-> ##2 !rdata_drv);

    a_r9_hold_address: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_strobe_n && ctrl_strobe_n && advance_n) |=> $stable(req_addr));

    a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> ##2 !rdata_drv);
endmodule

bind sync_burst_sram sync_burst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .advance_n     (advance_n),
    .en_a_n        (en_a_n),
    .en_b          (en_b),
    .en_c_n        (en_c_n),
    .write_all_n   (write_all_n),
    .sleep         (sleep),
    .out_en_n      (out_en_n),
    .rdata_drv     (rdata_drv),
    .req_op        (req_op),
    .req_addr      (req_addr),
    .req_mask      (req_mask)
);

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
    localparam int AW = 6;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, advance_n = 1'b1;
    logic          en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0;
    logic          write_all_n = 1'b1, byte_wr_en_n = 1'b1;
    logic [NL-1:0] lane_wr_n = '1;
    logic          burst_il = 1'b0, sleep = 1'b0, out_en_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_drv;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [DW-1:0] model [1 << AW];

    always #2 clk = ~clk;

    sync_burst_sram u_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strobe_n(proc_strobe_n),
        .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n), .en_a_n(en_a_n),
        .en_b(en_b), .en_c_n(en_c_n), .write_all_n(write_all_n),
        .byte_wr_en_n(byte_wr_en_n), .lane_wr_n(lane_wr_n), .burst_il(burst_il),
        .sleep(sleep), .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata),
        .rdata_drv(rdata_drv)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b1;
        en_a_n = 1'b0; en_b = 1'b1; en_c_n = 1'b0;
        write_all_n = 1'b1; byte_wr_en_n = 1'b1; lane_wr_n = '1;
        sleep = 1'b0; out_en_n = 1'b0;
    endtask

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [DW-1:0] exp);
        chk(req, {{(DW-1){1'b0}}, rdata_drv}, 1);
        chk(req, rdata, exp);
    endtask

    task automatic chk_off(input string req);
        chk(req, {{(DW-1){1'b0}}, rdata_drv}, 0);
    endtask

    // Controller-strobe write; full when all_w, else lanes from ln_n.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit all_w, input logic [NL-1:0] ln_n);
        ctrl_strobe_n = 1'b0; addr = a; wdata = d;
        write_all_n = !all_w; byte_wr_en_n = all_w; lane_wr_n = ln_n;
        for (int i = 0; i < NL; i++)
            if (all_w || !ln_n[i]) model[a][i*LW +: LW] = d[i*LW +: LW];
        step();
        idle();
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a);
        proc_strobe_n = 1'b0; addr = a;
        step();
        idle();
        step();
        chk_word(req, model[a]);
    endtask

    task automatic t_reset();
        chk_off("R12 reset");
        advance_n = 1'b0;
        step(); step(); step();
        chk_off("R12 advance without burst");
        idle();
    endtask

    task automatic t_full_write();
        wr(6'd5, 36'h1_2345_6789, 1'b1, 4'b1111);
        rd("R4 write_all", 6'd5);
        wr(6'd6, 36'hA_BCDE_F012, 1'b0, 4'b0000);
        rd("R4 all lanes", 6'd6);
    endtask

    task automatic t_byte_write();
        wr(6'd5, 36'hF_FFFF_FFFF, 1'b0, 4'b1010);
        rd("R5 lanes 0 and 2", 6'd5);
        ctrl_strobe_n = 1'b0; addr = 6'd6; wdata = '0;
        step(); idle(); step();
        chk_word("R5 no lane is read", model[6]);
        ctrl_strobe_n = 1'b0; addr = 6'd5; byte_wr_en_n = 1'b0; lane_wr_n = '1;
        step(); idle(); step();
        chk_word("R5 empty lane set is read", model[5]);
    endtask

    task automatic t_proc_read();
        wr(6'd4, 36'h0_0000_0444, 1'b1, 4'b1111);
        proc_strobe_n = 1'b0; addr = 6'd4; write_all_n = 1'b0; wdata = 36'hD_EAD0_0000;
        step(); idle(); step();
        chk_word("R3 proc strobe ignores write", model[4]);
        proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; addr = 6'd4;
        write_all_n = 1'b0; wdata = 36'hB_EEF0_0000;
        step(); idle(); step();
        chk_word("R3 proc strobe wins", model[4]);
        rd("R3 contents unchanged", 6'd4);
    endtask

    task automatic t_latency_hiz();
        wr(6'd1, 36'h0_1111_1111, 1'b1, 4'b1111);
        step();
        proc_strobe_n = 1'b0; addr = 6'd1;
        step(); idle();
        chk_off("R2 not yet after one edge");
        step();
        chk_word("R2 data after two edges", model[1]);
        wr(6'd2, 36'h0_2222_2222, 1'b1, 4'b1111);
        step();
        chk_off("R6 released after write");
        step(); step();
        chk_off("R6 still released");
        rd("R6 new read drives", 6'd2);
    endtask

    task automatic t_linear();
        for (int i = 8; i < 12; i++) wr(AW'(i), 36'h1_0000_0000 + 36'(i), 1'b1, 4'b1111);
        proc_strobe_n = 1'b0; addr = 6'd10; burst_il = 1'b0;
        step(); idle(); advance_n = 1'b0;
        step(); chk_word("R7 beat0", model[10]);
        step(); chk_word("R7 beat1", model[11]);
        step(); advance_n = 1'b1; chk_word("R7 wrap", model[8]);
        step(); chk_word("R7 beat3", model[9]);
        // Write burst 12,13,14.
        ctrl_strobe_n = 1'b0; addr = 6'd12; write_all_n = 1'b0; wdata = 36'h2_0000_000C;
        model[12] = wdata;
        step(); ctrl_strobe_n = 1'b1; advance_n = 1'b0; wdata = 36'h2_0000_000D;
        model[13] = wdata;
        step(); wdata = 36'h2_0000_000E;
        model[14] = wdata;
        step(); idle();
        rd("R7 write burst 12", 6'd12);
        rd("R7 write burst 13", 6'd13);
        rd("R7 write burst 14", 6'd14);
    endtask

    task automatic t_interleave();
        proc_strobe_n = 1'b0; addr = 6'd9; burst_il = 1'b1;
        step(); idle(); burst_il = 1'b0; advance_n = 1'b0;
        step(); chk_word("R8 beat0", model[9]);
        step(); chk_word("R8 beat1", model[8]);
        step(); advance_n = 1'b1; chk_word("R8 beat2", model[11]);
        step(); chk_word("R8 beat3", model[10]);
    endtask

    task automatic t_hold();
        proc_strobe_n = 1'b0; addr = 6'd10;
        step(); idle(); advance_n = 1'b0;
        step(); advance_n = 1'b1; chk_word("R9 start", model[10]);
        step(); advance_n = 1'b0; chk_word("R9 step", model[11]);
        step(); advance_n = 1'b1; chk_word("R9 held", model[11]);
        step(); chk_word("R9 resume", model[8]);
        ctrl_strobe_n = 1'b0; addr = 6'd20; write_all_n = 1'b0; wdata = 36'h3_0000_0001;
        step(); ctrl_strobe_n = 1'b1; wdata = 36'h3_0000_0002;
        model[20] = wdata;
        step(); idle();
        rd("R9 write repeats on held address", 6'd20);
    endtask

    task automatic t_oe();
        rd("R10 setup", 6'd1);
        out_en_n = 1'b1; #1;
        chk_off("R10 gate off at once");
        out_en_n = 1'b0; #1;
        chk_word("R10 gate on again", model[1]);
        step();
    endtask

    task automatic t_sleep();
        rd("R11 setup", 6'd2);
        proc_strobe_n = 1'b0; en_a_n = 1'b1;
        step(); idle();
        sleep = 1'b1; ctrl_strobe_n = 1'b0; addr = 6'd2; write_all_n = 1'b0;
        wdata = 36'h9_9999_9999;
        step(); step();
        proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b1;
        step(); step();
        chk_off("R11 quiet in sleep");
        idle();
        step(); step();
        chk_off("R11 undriven after sleep");
        rd("R11 contents kept", 6'd2);
    endtask

    task automatic t_deselect();
        wr(6'd3, 36'h0_3333_3333, 1'b1, 4'b1111);
        for (int c = 0; c < 3; c++) begin
            ctrl_strobe_n = 1'b0; addr = 6'd3; write_all_n = 1'b0; wdata = 36'h5_5555_5555;
            en_a_n = (c == 0); en_b = (c != 1); en_c_n = (c == 2);
            step(); idle(); step();
            rd("R1 deselected write ignored", 6'd3);
        end
        proc_strobe_n = 1'b0; en_b = 1'b0;
        step(); idle(); step();
        chk_off("R1 deselect releases bus");
    endtask

    initial begin
        idle();
        step(); step();
        chk_off("R12 in reset");
        rst_n = 1'b1;
        step();
        t_reset();
        t_full_write();
        t_byte_write();
        t_proc_read();
        t_latency_hiz();
        t_linear();
        t_interleave();
        t_hold();
        t_oe();
        t_sleep();
        t_deselect();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule